// File: doc/BRIEF.md
# Double-Buffered Converter Code Register Front End

This block is the digital front end of a 16-bit parallel-input digital-to-analog converter, modelled synchronously on a system clock. A host reaches it over an active-low chip select, a read/write select and a 16-bit data bus. The bus is split into separate data-in, data-out and output-enable ports. A host write fills a staging register. A host read returns the staging register on the bus. The converter code is held in a second register, and only a rising edge on a load strobe moves the staged word into it. A new code can therefore be prepared while the old one is still being converted.

A rising edge on a reset pin forces both registers to mid-scale (0x8000) or to zero, as chosen by a reset-select pin. A power-on synchronous reset clears both registers to zero before the host's first access. Every host pin passes through a two-flop synchronizer, and this includes the data bus. Edges are detected after synchronization, so each action happens at a fixed latency after the pin changes.

Top module: `dacif_regs`

## Requirements
- R1: While `rstN` is low, and on the first clock after it, `dacCode` is 0x0000, the staging register is 0x0000 and `busOe` is 0.
- R2: While `csN` is 0 and `rdWr` is 0, the staging register takes the synchronized `busIn` value, and `dacCode` keeps its value.
- R3: `busOe` is 1 exactly when the synchronized `csN` is 0 and `rdWr` is 1. While it is 1, `busOut` equals the staging register.
- R4: A 0-to-1 transition of `ldStrobe` copies the staging register into `dacCode` exactly once. A held high or held low level has no effect.
- R5: Writes to the staging register never change `dacCode` until the next load edge.
- R6: A 0-to-1 transition of `rstPin` sets both registers to 0x8000 when `rstSel` is 1, and to 0x0000 when `rstSel` is 0.
- R7: When a reset edge coincides with a write and a load edge, the reset value wins in both registers.
- R8: When a load edge coincides with a write, `dacCode` takes the staging value from before the write and the staging register takes the new bus value.
- R9: A pin change that is driven between clock edges shows on `busOe` after the second rising clock edge, and on the registers after the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-on synchronous reset, active low |
| csN | input | 1 | Host chip select, active low |
| rdWr | input | 1 | 1 selects a read, 0 selects a write |
| ldStrobe | input | 1 | Load strobe, acts on its rising edge |
| rstPin | input | 1 | Register reset, acts on its rising edge |
| rstSel | input | 1 | Reset value select: 1 gives mid-scale, 0 gives zero |
| busIn | input | 16 | Host write data |
| busOut | output | 16 | Host read data (staging register) |
| busOe | output | 1 | Drive enable for the host data bus |
| dacCode | output | 16 | Code presented to the converter |

## Verification
The bench drives directed sequences and compares them cycle by cycle against a behavioural model. One sequence holds the load strobe high for many cycles while writing, which separates edge action from level action. Another puts a write and a load edge in the same cycle, which shows whether the converter register sees the old or the new staging word. A third puts a reset edge on top of both, to check priority, with each reset-select value. A long random stream of pin activity then follows. It catches latency slips, because the model counts the synchronizer stages itself.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  typedef struct packed {
    logic write;
    logic load;
    logic reset;
    logic resetMid;
  } dacStrobes_t;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] level
);
  localparam int STAGES = 2;
  logic [W-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= RESET_VAL;
        else if (s == 0) stage[s] <= pinIn;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign level = stage[STAGES-1];
endmodule

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
  import dacif_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        rdWr,
  input  logic        ldStrobe,
  input  logic        rstPin,
  input  logic        rstSel,
  output dacStrobes_t strb,
  output logic        readEn
);
  localparam int NCTL   = 5;
  localparam int IDX_CS = 0;
  localparam int IDX_RW = 1;
  localparam int IDX_LD = 2;
  localparam int IDX_RS = 3;
  localparam int IDX_SL = 4;
  localparam logic [NCTL-1:0] IDLE = NCTL'(3);

  logic [NCTL-1:0] ctlLevel;
  logic ldLast, rsLast;
  logic ldRise, rsRise;

  dacif_sync #(.W(NCTL), .RESET_VAL(IDLE)) u_sync (
    .clk(clk), .rstN(rstN),
    .pinIn({rstSel, rstPin, ldStrobe, rdWr, csN}),
    .level(ctlLevel)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldLast <= 1'b0;
      rsLast <= 1'b0;
    end else begin
      ldLast <= ctlLevel[IDX_LD];
      rsLast <= ctlLevel[IDX_RS];
    end
  end

  assign ldRise = ctlLevel[IDX_LD] & ~ldLast;
  assign rsRise = ctlLevel[IDX_RS] & ~rsLast;

  always_comb begin
    strb.write    = ~ctlLevel[IDX_CS] & ~ctlLevel[IDX_RW];
    strb.load     = ldRise;
    strb.reset    = rsRise;
    strb.resetMid = ctlLevel[IDX_SL];
  end
  assign readEn = ~ctlLevel[IDX_CS] & ctlLevel[IDX_RW];

  // R4: an edge gives a pulse one cycle wide
  assert_load_pulse_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    ldRise |=> !ldRise);
  assert_reset_pulse_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    rsRise |=> !rsRise);
endmodule

// File: rtl/dacif_datapath.sv
module dacif_datapath
  import dacif_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dacStrobes_t   strb,
  input  logic [DW-1:0] busIn,
  output logic [DW-1:0] inReg,
  output logic [DW-1:0] dacReg
);
  localparam logic [DW-1:0] MID_CODE  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] ZERO_CODE = '0;

  logic [DW-1:0] busSync;

  dacif_sync #(.W(DW), .RESET_VAL(ZERO_CODE)) u_dsync (
    .clk(clk), .rstN(rstN), .pinIn(busIn), .level(busSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg  <= ZERO_CODE;
      dacReg <= ZERO_CODE;
    end else if (strb.reset) begin
      inReg  <= strb.resetMid ? MID_CODE : ZERO_CODE;
      dacReg <= strb.resetMid ? MID_CODE : ZERO_CODE;
    end else begin
      if (strb.load)  dacReg <= inReg;
      if (strb.write) inReg  <= busSync;
    end
  end

  // R5: the converter register moves only on a load or reset strobe
  assert_dac_moves_on_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dacReg != $past(dacReg)) |-> $past(strb.load || strb.reset));
  // R2: the staging register moves only on a write or reset strobe
  assert_stage_moves_on_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inReg != $past(inReg)) |-> $past(strb.write || strb.reset));
  // R6: after a reset strobe both registers hold the same legal reset code
  assert_reset_value_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.reset |=> (inReg == dacReg) && (dacReg == MID_CODE || dacReg == ZERO_CODE));
  // R8: a load with a write takes the older staging word
  assert_load_old_word_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.write && !strb.reset) |=> dacReg == $past(inReg));
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
  import dacif_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          rdWr,
  input  logic          ldStrobe,
  input  logic          rstPin,
  input  logic          rstSel,
  input  logic [DW-1:0] busIn,
  output logic [DW-1:0] busOut,
  output logic          busOe,
  output logic [DW-1:0] dacCode
);
  dacStrobes_t   strb;
  logic          readEn;
  logic [DW-1:0] inReg;

  dacif_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdWr(rdWr), .ldStrobe(ldStrobe),
    .rstPin(rstPin), .rstSel(rstSel), .strb(strb), .readEn(readEn)
  );

  dacif_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busIn(busIn),
    .inReg(inReg), .dacReg(dacCode)
  );

  assign busOut = inReg;
  assign busOe  = readEn;
endmodule

// File: tb/tb_dacif_regs.sv
`timescale 1ns/1ps
module tb_dacif_regs;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rdWr = 1'b1, ldStrobe = 1'b0, rstPin = 1'b0, rstSel = 1'b0;
  logic [15:0] busIn = 16'h0;
  logic [15:0] busOut, dacCode;
  logic busOe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  dacif_regs dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdWr(rdWr), .ldStrobe(ldStrobe),
    .rstPin(rstPin), .rstSel(rstSel), .busIn(busIn), .busOut(busOut),
    .busOe(busOe), .dacCode(dacCode)
  );

  // behavioural reference: pin samples taken at each edge, newest first
  logic hCs [4], hRw [4], hLd [4], hRs [4], hSl [4];
  logic [15:0] hData [4];
  logic [15:0] mIn = 0, mDac = 0;
  logic mOe = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin
        hCs[i] = 1; hRw[i] = 1; hLd[i] = 0; hRs[i] = 0; hSl[i] = 0; hData[i] = 0;
      end
      mIn = 0; mDac = 0; mOe = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin
        hCs[i] = hCs[i-1]; hRw[i] = hRw[i-1]; hLd[i] = hLd[i-1];
        hRs[i] = hRs[i-1]; hSl[i] = hSl[i-1]; hData[i] = hData[i-1];
      end
      hCs[0] = csN; hRw[0] = rdWr; hLd[0] = ldStrobe;
      hRs[0] = rstPin; hSl[0] = rstSel; hData[0] = busIn;
      // pins sampled two edges back are acted on now (R9)
      if (hRs[2] && !hRs[3]) begin
        mIn = hSl[2] ? 16'h8000 : 16'h0000;
        mDac = mIn;
      end else begin
        if (hLd[2] && !hLd[3]) mDac = mIn;
        if (!hCs[2] && !hRw[2]) mIn = hData[2];
      end
      mOe = !hCs[1] && hRw[1];
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check(curReq, "dacCode", dacCode, mDac);
      check(curReq, "busOe", busOe, mOe);
      if (busOe) check(curReq, "busOut", busOut, mIn);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [15:0] v);
    csN = 0; rdWr = 0; busIn = v;
    waitN(1);
    csN = 1; rdWr = 1;
  endtask

  initial begin
    waitN(4);
    check("R1", "reset dacCode", dacCode, 0);
    check("R1", "reset busOe", busOe, 0);
    rstN = 1;
    waitN(1);
    check("R1", "first cycle dacCode", dacCode, 0);

    curReq = "R2";
    hostWrite(16'h1234);
    waitN(4);
    check("R2", "dac held after write", dacCode, 0);

    curReq = "R3";
    csN = 0; rdWr = 1;
    waitN(1);
    check("R9", "oe not yet", busOe, 0);
    waitN(1);
    check("R3", "oe on read", busOe, 1);
    check("R3", "read data", busOut, 16'h1234);
    csN = 1;
    waitN(3);
    check("R3", "oe released", busOe, 0);

    curReq = "R4";
    ldStrobe = 1;
    waitN(2);
    check("R9", "load not yet", dacCode, 0);
    waitN(1);
    check("R9", "load after third edge", dacCode, 16'h1234);
    curReq = "R5";
    hostWrite(16'h5555);
    waitN(6);
    check("R4", "held high level no reload", dacCode, 16'h1234);
    check("R5", "staging isolated", dacCode, 16'h1234);
    ldStrobe = 0;
    waitN(5);
    check("R4", "falling edge no effect", dacCode, 16'h1234);
    curReq = "R4";
    ldStrobe = 1;
    waitN(4);
    check("R4", "second load", dacCode, 16'h5555);
    ldStrobe = 0;
    waitN(3);

    curReq = "R6";
    rstSel = 1; rstPin = 1;
    waitN(4);
    check("R6", "mid-scale dac", dacCode, 16'h8000);
    rstPin = 0;
    hostWrite(16'hABCD);
    waitN(4);
    rstSel = 0;
    waitN(1);
    rstPin = 1;
    waitN(4);
    check("R6", "zero-scale dac", dacCode, 0);
    csN = 0; rdWr = 1;
    waitN(3);
    check("R6", "zero-scale staging", busOut, 0);
    csN = 1; rstPin = 0;
    waitN(3);

    curReq = "R8";
    hostWrite(16'h0F0F);
    waitN(4);
    csN = 0; rdWr = 0; busIn = 16'hF0F0; ldStrobe = 1;
    waitN(1);
    csN = 1; rdWr = 1;
    waitN(4);
    check("R8", "dac got older word", dacCode, 16'h0F0F);
    ldStrobe = 0;
    waitN(2);
    ldStrobe = 1;
    waitN(4);
    check("R8", "new word staged", dacCode, 16'hF0F0);
    ldStrobe = 0;
    waitN(3);

    curReq = "R7";
    rstSel = 1;
    waitN(2);
    csN = 0; rdWr = 0; busIn = 16'h7777; ldStrobe = 1; rstPin = 1;
    waitN(1);
    csN = 1; rdWr = 1;
    waitN(4);
    check("R7", "reset beats load", dacCode, 16'h8000);
    ldStrobe = 0; rstPin = 0;
    waitN(3);

    curReq = "R9";
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      csN = r < 60 ? 0 : 1;
      rdWr = $urandom_range(0, 1);
      busIn = 16'($urandom);
      ldStrobe = $urandom_range(0, 3) == 0 ? ~ldStrobe : ldStrobe;
      rstPin = $urandom_range(0, 40) == 0 ? ~rstPin : rstPin;
      if (!rstPin) rstSel = $urandom_range(0, 1);
      waitN(1);
    end
    waitN(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule